// File: doc/BRIEF.md
# Quad-to-Double Floating-Point Narrowing Converter

This block narrows one IEEE 754 binary128 operand to binary64 in a single registered stage. The caller presents a 128-bit operand together with a 2-bit rounding-mode code and a 5-bit trap-enable mask, and asserts `in_valid`. One clock later the 64-bit result, the five current-exception flags, the update for the accrued-exception flags and a trap request appear together with `out_valid`.

Every operand class is covered: NaNs, which are quietened with their payload kept; infinities; signed zeros; operands too large for binary64, which saturate according to the rounding mode; operands too small for binary64, which collapse to zero or to the smallest subnormal; operands in the binary64 subnormal range, which are denormalized by a variable right shift; and normal operands, which are rebiased. Rounding uses a round bit and a sticky bit. Before rounding, the operand sign is folded into the mode so that the two directed modes act as toward-zero or away-from-zero on the magnitude.

Top module: `q2d_convert`

## Requirements
- R1: Outputs are registered. `out_valid` is asserted exactly one cycle after `in_valid`, and the other outputs change only for a valid input. A synchronous active-high reset clears every output to zero.
- R2: Flag vectors use bit 0 for inexact, bit 1 for divide-by-zero, bit 2 for underflow, bit 3 for overflow and bit 4 for invalid. The trap mask uses the same bit positions. Divide-by-zero is never raised.
- R3: An operand with exponent 0x7FFF and a nonzero fraction gives {sign, exponent 0x7FF, bit 51 set, bits 50..0 taken from operand fraction bits 110..60}. Invalid is raised only when operand fraction bit 111 is 0.
- R4: An operand with exponent 0x7FFF and a zero fraction gives infinity with the same sign and no flags.
- R5: A zero operand of either sign gives a zero of the same sign and no flags, in every mode.
- R6: Rounding-mode codes are 0 nearest-even, 1 toward zero, 2 toward +inf and 3 toward -inf. For a negative operand, codes 2 and 3 are swapped before use. For a finite operand with exponent at or above 0x43FF: folded mode 0 or 2 gives signed infinity, and folded mode 1 or 3 gives signed 0x7FEFFFFFFFFFFFFF. Overflow and inexact are raised.
- R7: A nonzero operand with exponent below 0x3BCC gives a signed zero. When the folded mode is 2, the low result bit is set instead. Underflow and inexact are raised.
- R8: For exponents 0x3C01..0x43FE, the result exponent is the operand exponent minus 0x3C00 and the result fraction is operand fraction bits 111..60. Bit 59 is the round bit and the OR of bits 58..0 is the sticky bit.
- R9: For exponents 0x3BCC..0x3C00, the significand with its hidden 1 is shifted right by 0x3C01 minus the exponent into a zero-exponent result. Every bit shifted out feeds the round and sticky bits.
- R10: The magnitude is incremented when the folded mode is 2 and round or sticky is set. It is also incremented when the folded mode is 0, round is set, and either sticky or the result LSB is set.
- R11: An increment that carries the exponent to 0x7FF gives infinity and raises overflow.
- R12: Inexact is raised when round or sticky is set. In the subnormal range underflow is raised as well. An exact subnormal result raises underflow only when trap-enable bit 2 is set.
- R13: `out_trap` is set when any raised flag is also enabled in the trap mask. In that case the accrued update is zero; otherwise the accrued update equals the raised flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand valid |
| in_operand | input | 128 | binary128 operand |
| in_rmode | input | 2 | Rounding-mode code |
| in_trap_en | input | 5 | Trap-enable mask |
| out_valid | output | 1 | Result valid |
| out_result | output | 64 | binary64 result |
| out_cexc | output | 5 | Current-exception flags |
| out_aexc_upd | output | 5 | Bits to OR into the accrued flags |
| out_trap | output | 1 | Trap request |

## Verification
Two functions can coincide in one cycle: a rounding increment that carries into the all-ones exponent, and the trap decision that the resulting overflow flag feeds. The bench provokes this with an operand of exponent 0x43FE and a fraction whose top 53 bits are all ones, under nearest-even. It converts that operand once with the overflow trap disabled and once with it enabled. The result must be infinity with overflow and inexact in both cases, and the trap request and accrued update must switch between the two runs in the same cycle as the result. A second such pair is the exact subnormal result, where the underflow flag exists only because of the trap mask that it then trips.

// File: rtl/q2d_pkg.sv
package q2d_pkg;
  localparam int QW        = 128;
  localparam int QEXP_W    = 15;
  localparam int QFRAC_W   = 112;
  localparam int DW        = 64;
  localparam int DEXP_W    = 11;
  localparam int DFRAC_W   = 52;
  localparam int QBIAS     = (1 << (QEXP_W - 1)) - 1;
  localparam int DBIAS     = (1 << (DEXP_W - 1)) - 1;
  localparam int BIAS_GAP  = QBIAS - DBIAS;                    // 0x3C00
  localparam int QEXP_OVF  = BIAS_GAP + (1 << DEXP_W) - 1;     // 0x43FF
  localparam int QEXP_NORM = BIAS_GAP + 1;                     // 0x3C01
  localparam int QEXP_SUB  = BIAS_GAP - DFRAC_W;               // 0x3BCC
  localparam int MAX_SHIFT = DFRAC_W + 1;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int NFLAG     = 5;

  localparam int FLG_NX = 0;
  localparam int FLG_DZ = 1;
  localparam int FLG_UF = 2;
  localparam int FLG_OF = 3;
  localparam int FLG_NV = 4;

  localparam logic [1:0] RM_NEAR = 2'd0;
  localparam logic [1:0] RM_ZERO = 2'd1;
  localparam logic [1:0] RM_UP   = 2'd2;
  localparam logic [1:0] RM_DOWN = 2'd3;

  typedef enum logic [2:0] {
    CLS_NAN, CLS_INF, CLS_BIG, CLS_ZERO, CLS_TINY, CLS_SUB, CLS_NORM
  } opclass_t;
endpackage

// File: rtl/q2d_classify.sv
module q2d_classify
  import q2d_pkg::*;
(
  input  logic [QEXP_W-1:0]  qexp,
  input  logic               frac_nz,
  input  logic               sign,
  input  logic [1:0]         rmode,
  output opclass_t           cls,
  output logic [1:0]         fmode,
  output logic [DEXP_W-1:0]  dexp,
  output logic [SHIFT_W-1:0] shift
);
  int ex;
  assign ex = int'(qexp);

  // directed modes become toward/away from zero on the magnitude
  assign fmode = sign ? (rmode ^ {1'b0, rmode[1]}) : rmode;

  always_comb begin
    if (qexp == '1)            cls = frac_nz ? CLS_NAN : CLS_INF;
    else if (ex >= QEXP_OVF)   cls = CLS_BIG;
    else if (ex == 0 && !frac_nz) cls = CLS_ZERO;
    else if (ex < QEXP_SUB)    cls = CLS_TINY;
    else if (ex < QEXP_NORM)   cls = CLS_SUB;
    else                       cls = CLS_NORM;
  end

  assign dexp  = (cls == CLS_NORM) ? DEXP_W'(ex - BIAS_GAP) : '0;
  assign shift = (cls == CLS_SUB) ? SHIFT_W'(QEXP_NORM - ex) : '0;
endmodule

// File: rtl/q2d_align.sv
module q2d_align #(
  parameter int IN_W  = 112,
  parameter int OUT_W = 52,
  parameter int SH_W  = 6
) (
  input  logic [IN_W-1:0]  frac,
  input  logic [SH_W-1:0]  shift,
  output logic [OUT_W-1:0] mant,
  output logic             rnd,
  output logic             sticky
);
  localparam int W         = IN_W + 1;
  localparam int GUARD_POS = IN_W - OUT_W - 1;

  logic [W-1:0]    full;
  logic [IN_W-1:0] kept;
  logic [W-1:0]    lost_mask;

  assign full      = {1'b1, frac};
  assign kept      = IN_W'(full >> shift);
  assign lost_mask = (W'(1) << shift) - W'(1);
  assign mant      = kept[IN_W-1 -: OUT_W];
  assign rnd       = kept[GUARD_POS];
  assign sticky    = (|kept[GUARD_POS-1:0]) | (|(full & lost_mask));
endmodule

// File: rtl/q2d_round.sv
module q2d_round
  import q2d_pkg::*;
#(
  parameter int EXP_W  = 11,
  parameter int FRAC_W = 52
) (
  input  logic [EXP_W-1:0]        dexp,
  input  logic [FRAC_W-1:0]       mant,
  input  logic                    rnd,
  input  logic                    sticky,
  input  logic [1:0]              fmode,
  input  logic                    subn,
  input  logic                    uf_trap_en,
  output logic [EXP_W+FRAC_W-1:0] mag,
  output logic                    nx,
  output logic                    uf,
  output logic                    of
);
  logic inc;

  assign inc = ((fmode == RM_UP) && (rnd | sticky)) ||
               ((fmode == RM_NEAR) && rnd && (sticky | mant[0]));
  assign mag = {dexp, mant} + (EXP_W+FRAC_W)'(inc);
  assign of  = &mag[EXP_W+FRAC_W-1 -: EXP_W];
  assign nx  = rnd | sticky;
  assign uf  = subn & (rnd | sticky | uf_trap_en);
endmodule

// File: rtl/q2d_convert.sv
module q2d_convert
  import q2d_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [QW-1:0]    in_operand,
  input  logic [1:0]       in_rmode,
  input  logic [NFLAG-1:0] in_trap_en,
  output logic             out_valid,
  output logic [DW-1:0]    out_result,
  output logic [NFLAG-1:0] out_cexc,
  output logic [NFLAG-1:0] out_aexc_upd,
  output logic             out_trap
);
  logic                      sign;
  logic [QEXP_W-1:0]         qexp;
  logic [QFRAC_W-1:0]        frac;
  opclass_t                  cls;
  logic [1:0]                fmode;
  logic [DEXP_W-1:0]         dexp;
  logic [SHIFT_W-1:0]        shift;
  logic [DFRAC_W-1:0]        mant;
  logic                      rnd, sticky;
  logic [DEXP_W+DFRAC_W-1:0] mag;
  logic                      r_nx, r_uf, r_of;
  logic [DW-1:0]             res_d;
  logic [NFLAG-1:0]          cx_d;
  logic                      trap_d;

  assign sign = in_operand[QW-1];
  assign qexp = in_operand[QW-2 -: QEXP_W];
  assign frac = in_operand[QFRAC_W-1:0];

  q2d_classify u_class (
    .qexp(qexp), .frac_nz(|frac), .sign(sign), .rmode(in_rmode),
    .cls(cls), .fmode(fmode), .dexp(dexp), .shift(shift)
  );

  q2d_align #(.IN_W(QFRAC_W), .OUT_W(DFRAC_W), .SH_W(SHIFT_W)) u_align (
    .frac(frac), .shift(shift), .mant(mant), .rnd(rnd), .sticky(sticky)
  );

  q2d_round #(.EXP_W(DEXP_W), .FRAC_W(DFRAC_W)) u_round (
    .dexp(dexp), .mant(mant), .rnd(rnd), .sticky(sticky), .fmode(fmode),
    .subn(cls == CLS_SUB), .uf_trap_en(in_trap_en[FLG_UF]),
    .mag(mag), .nx(r_nx), .uf(r_uf), .of(r_of)
  );

  always_comb begin
    cx_d = '0;
    unique case (cls)
      CLS_NAN: begin
        res_d = {sign, {DEXP_W{1'b1}}, 1'b1, frac[QFRAC_W-2 -: DFRAC_W-1]};
        cx_d[FLG_NV] = ~frac[QFRAC_W-1];
      end
      CLS_INF:  res_d = {sign, {DEXP_W{1'b1}}, {DFRAC_W{1'b0}}};
      CLS_BIG: begin
        if (fmode == RM_NEAR || fmode == RM_UP)
          res_d = {sign, {DEXP_W{1'b1}}, {DFRAC_W{1'b0}}};
        else
          res_d = {sign, {(DEXP_W-1){1'b1}}, 1'b0, {DFRAC_W{1'b1}}};
        cx_d[FLG_OF] = 1'b1;
        cx_d[FLG_NX] = 1'b1;
      end
      CLS_ZERO: res_d = {sign, {(DW-1){1'b0}}};
      CLS_TINY: begin
        res_d = {sign, {(DW-2){1'b0}}, fmode == RM_UP};
        cx_d[FLG_UF] = 1'b1;
        cx_d[FLG_NX] = 1'b1;
      end
      default: begin
        res_d = {sign, mag};
        cx_d[FLG_NX] = r_nx;
        cx_d[FLG_UF] = r_uf;
        cx_d[FLG_OF] = r_of;
      end
    endcase
  end

  assign trap_d = |(cx_d & in_trap_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_cexc     <= '0;
      out_aexc_upd <= '0;
      out_trap     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result   <= res_d;
        out_cexc     <= cx_d;
        out_aexc_upd <= trap_d ? '0 : cx_d;
        out_trap     <= trap_d;
      end
    end
  end
endmodule

// File: rtl/q2d_convert_chk.sv
module q2d_convert_chk (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [127:0] in_operand,
  input logic [4:0]   in_trap_en,
  input logic         out_valid,
  input logic [63:0]  out_result,
  input logic [4:0]   out_cexc,
  input logic [4:0]   out_aexc_upd,
  input logic         out_trap
);
  logic is_nan, is_inf, is_zero;
  assign is_nan  = (&in_operand[126:112]) && (|in_operand[111:0]);
  assign is_inf  = (&in_operand[126:112]) && !(|in_operand[111:0]);
  assign is_zero = in_operand[126:0] == '0;

  assert_valid_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_no_divzero_R2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_cexc[1]);
  assert_nan_quiet_R3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_nan) |=>
      (out_result[62:51] == 12'hFFF && out_cexc[4] == !$past(in_operand[111])));
  assert_inf_exact_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_inf) |=>
      (out_result == {$past(in_operand[127]), 11'h7FF, 52'h0} && out_cexc == 5'b0));
  assert_zero_signed_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_zero) |=>
      (out_result == {$past(in_operand[127]), 63'h0} && out_cexc == 5'b0));
  assert_overflow_inexact_R11: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_cexc[3]) |-> out_cexc[0]);
  assert_trap_mask_R13: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_trap == |(out_cexc & $past(in_trap_en))));
  assert_trap_no_accrue_R13: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_trap) |-> out_aexc_upd == 5'b0);
endmodule

bind q2d_convert q2d_convert_chk u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
  .in_trap_en(in_trap_en), .out_valid(out_valid), .out_result(out_result),
  .out_cexc(out_cexc), .out_aexc_upd(out_aexc_upd), .out_trap(out_trap)
);

// File: tb/q2d_convert_bench.sv
`timescale 1ns/1ps
module q2d_convert_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] in_operand = '0;
  logic [1:0]   in_rmode = '0;
  logic [4:0]   in_trap_en = '0;
  logic         out_valid;
  logic [63:0]  out_result;
  logic [4:0]   out_cexc, out_aexc_upd;
  logic         out_trap;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  q2d_convert u_q2d_convert (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_operand(in_operand),
    .in_rmode(in_rmode), .in_trap_en(in_trap_en), .out_valid(out_valid),
    .out_result(out_result), .out_cexc(out_cexc), .out_aexc_upd(out_aexc_upd),
    .out_trap(out_trap)
  );

  // behavioural model: returns {flags, result}
  function automatic logic [68:0] ref_model(input logic [127:0] op, input logic [1:0] rm,
                                            input logic [4:0] te);
    logic s; int e; logic [111:0] f; logic [1:0] fm; logic [63:0] r; logic [4:0] c;
    logic [52:0] sig; logic g, st, up; int ex; logic [62:0] v;
    s = op[127]; e = int'(op[126:112]); f = op[111:0]; c = '0;
    fm = rm;
    if (s && rm == 2'd2) fm = 2'd3;
    else if (s && rm == 2'd3) fm = 2'd2;
    if (e == 32767) begin
      if (f != '0) begin r = {s, 11'h7FF, 1'b1, f[110:60]}; c[4] = !f[111]; end
      else r = {s, 11'h7FF, 52'h0};
    end else if (e >= 17407) begin
      r = (fm == 2'd0 || fm == 2'd2) ? {s, 11'h7FF, 52'h0} : {s, 11'h7FE, {52{1'b1}}};
      c = 5'b01001;
    end else if (e == 0 && f == '0) begin
      r = {s, 63'h0};
    end else if (e < 15308) begin
      r = {s, 62'h0, fm == 2'd2};
      c = 5'b00101;
    end else begin
      sig = {1'b1, f[111:60]}; g = f[59]; st = |f[58:0]; ex = 0;
      if (e >= 15361) ex = e - 15360;
      else for (int i = 0; i < 15361 - e; i++) begin
        st = st | g; g = sig[0]; sig = sig >> 1;
      end
      v = {ex[10:0], sig[51:0]};
      up = (fm == 2'd2 && (g || st)) || (fm == 2'd0 && g && (st || sig[0]));
      v = v + 63'(up);
      r = {s, v};
      if (v[62:52] == 11'h7FF) c[3] = 1'b1;
      if (g || st) c[0] = 1'b1;
      if (e < 15361 && (g || st || te[2])) c[2] = 1'b1;
    end
    return {c, r};
  endfunction

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [127:0] op, input logic [1:0] rm, input logic [4:0] te);
    @(negedge clk);
    in_valid = 1'b1; in_operand = op; in_rmode = rm; in_trap_en = te;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  // convert, compare to model and optionally to a fixed expected value
  task automatic conv(input string req, input logic [127:0] op, input logic [1:0] rm,
                      input logic [4:0] te, input bit fixed = 0,
                      input logic [63:0] xres = '0, input logic [4:0] xflg = '0);
    logic [68:0] m; logic [4:0] mc; logic mt;
    m = ref_model(op, rm, te);
    mc = m[68:64]; mt = |(mc & te);
    apply(op, rm, te);
    check({req, " valid"}, 64'(out_valid), 64'd1);
    check({req, " result"}, out_result, m[63:0]);
    check({req, " flags"}, 64'(out_cexc), 64'(mc));
    check({req, " trap R13"}, 64'(out_trap), 64'(mt));
    check({req, " accrued R13"}, 64'(out_aexc_upd), 64'(mt ? 5'b0 : mc));
    if (fixed) begin
      check({req, " fixed result"}, out_result, xres);
      check({req, " fixed flags"}, 64'(out_cexc), 64'(xflg));
    end
  endtask

  function automatic logic [127:0] mk(input logic s, input logic [14:0] e, input logic [111:0] f);
    return {s, e, f};
  endfunction

  function automatic logic [111:0] rfrac();
    return {$urandom(), $urandom(), $urandom(), 16'($urandom())};
  endfunction

  task automatic t_reset();
    rst = 1'b1; in_valid = 1'b1; in_operand = mk(0, 15'h3FFF, '0);
    repeat (3) @(negedge clk);
    check("R1 reset valid", 64'(out_valid), 64'd0);
    check("R1 reset result", out_result, 64'd0);
    check("R1 reset flags", 64'({out_cexc, out_aexc_upd, out_trap}), 64'd0);
    in_valid = 1'b0; rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_latency();
    apply(mk(0, 15'h3FFF, '0), 2'd0, 5'd0);
    check("R1 one-cycle valid", 64'(out_valid), 64'd1);
    check("R1 one-cycle result", out_result, 64'h3FF0000000000000);
    @(negedge clk);
    check("R1 valid drops", 64'(out_valid), 64'd0);
    check("R1 result held", out_result, 64'h3FF0000000000000);
  endtask

  task automatic t_nan();
    conv("R3 snan", mk(0, 15'h7FFF, 112'h1), 2'd0, 5'd0, 1, 64'h7FF8000000000000, 5'b10000);
    conv("R3 snan trap", mk(1, 15'h7FFF, {1'b0, 111'h5A5}), 2'd1, 5'b10000);
    conv("R3 qnan payload", mk(1, 15'h7FFF, {1'b1, 3'b101, 108'h0}), 2'd2, 5'd31, 1,
         64'hFFFD000000000000, 5'b00000);
    conv("R2 nan no divzero", mk(0, 15'h7FFF, rfrac()), 2'd3, 5'd0);
  endtask

  task automatic t_inf();
    conv("R4 +inf", mk(0, 15'h7FFF, '0), 2'd1, 5'd31, 1, 64'h7FF0000000000000, 5'd0);
    conv("R4 -inf", mk(1, 15'h7FFF, '0), 2'd0, 5'd0, 1, 64'hFFF0000000000000, 5'd0);
  endtask

  task automatic t_zero();
    for (int m = 0; m < 4; m++) begin
      conv("R5 +0", mk(0, 15'h0, '0), 2'(m), 5'd31, 1, 64'h0, 5'd0);
      conv("R5 -0", mk(1, 15'h0, '0), 2'(m), 5'd31, 1, 64'h8000000000000000, 5'd0);
    end
  endtask

  task automatic t_big();
    conv("R6 big rz", mk(0, 15'h43FF, '0), 2'd1, 5'd0, 1, 64'h7FEFFFFFFFFFFFFF, 5'b01001);
    conv("R6 big rn", mk(1, 15'h43FF, '0), 2'd0, 5'd0, 1, 64'hFFF0000000000000, 5'b01001);
    conv("R6 big neg rdown", mk(1, 15'h5000, '0), 2'd3, 5'd0, 1, 64'hFFF0000000000000, 5'b01001);
    conv("R6 big neg rup", mk(1, 15'h7FFE, '1), 2'd2, 5'd0, 1, 64'hFFEFFFFFFFFFFFFF, 5'b01001);
    for (int m = 0; m < 4; m++)
      conv("R6 big modes", mk(1'(m), 15'h43FF, rfrac()), 2'(m), 5'b01000);
  endtask

  task automatic t_tiny();
    conv("R7 tiny rz", mk(0, 15'h3BCB, '1), 2'd1, 5'd0, 1, 64'h0, 5'b00101);
    conv("R7 tiny neg rdown", mk(1, 15'h3BCB, '0), 2'd3, 5'd0, 1, 64'h8000000000000001, 5'b00101);
    conv("R7 quad subnormal rup", mk(0, 15'h0, 112'h1), 2'd2, 5'd0, 1, 64'h1, 5'b00101);
    conv("R7 tiny neg rup", mk(1, 15'h0001, '0), 2'd2, 5'd0, 1, 64'h8000000000000000, 5'b00101);
  endtask

  task automatic t_normal();
    conv("R8 one", mk(0, 15'h3FFF, '0), 2'd0, 5'd0, 1, 64'h3FF0000000000000, 5'd0);
    conv("R8 min normal", mk(0, 15'h3C01, '0), 2'd0, 5'd0, 1, 64'h0010000000000000, 5'd0);
    conv("R8 max exp trunc", mk(1, 15'h43FE, '1), 2'd1, 5'd0, 1, 64'hFFEFFFFFFFFFFFFF, 5'b00001);
    conv("R8 normal random", mk(0, 15'h4123, rfrac()), 2'd0, 5'd0);
  endtask

  task automatic t_sub();
    conv("R9 top subnormal", mk(0, 15'h3C00, '0), 2'd0, 5'd0, 1, 64'h0008000000000000, 5'd0);
    conv("R9 min subnormal", mk(0, 15'h3BCD, '0), 2'd1, 5'd0, 1, 64'h1, 5'd0);
    for (int e = 15308; e <= 15360; e++)
      conv("R9 subnormal sweep", mk(1'(e), 15'(e), rfrac()), 2'(e), 5'd0);
  endtask

  task automatic t_round();
    conv("R10 tie even stays", mk(0, 15'h3FFF, {52'h0, 1'b1, 59'h0}), 2'd0, 5'd0, 1,
         64'h3FF0000000000000, 5'b00001);
    conv("R10 tie odd up", mk(0, 15'h3FFF, {52'h1, 1'b1, 59'h0}), 2'd0, 5'd0, 1,
         64'h3FF0000000000002, 5'b00001);
    conv("R10 sticky rup", mk(0, 15'h3FFF, {52'h0, 1'b0, 59'h1}), 2'd2, 5'd0, 1,
         64'h3FF0000000000001, 5'b00001);
    conv("R10 neg rdown away", mk(1, 15'h3FFF, {52'h0, 1'b0, 59'h1}), 2'd3, 5'd0, 1,
         64'hBFF0000000000001, 5'b00001);
    conv("R10 neg rup toward zero", mk(1, 15'h3FFF, {52'h0, 1'b1, 59'h1}), 2'd2, 5'd0, 1,
         64'hBFF0000000000000, 5'b00001);
    conv("R10 half-min subnormal tie", mk(0, 15'h3BCC, '0), 2'd0, 5'd0, 1, 64'h0, 5'b00101);
  endtask

  task automatic t_carry();
    conv("R11 carry to inf", mk(0, 15'h43FE, '1), 2'd0, 5'd0, 1, 64'h7FF0000000000000, 5'b01001);
    conv("R11 carry with trap", mk(1, 15'h43FE, '1), 2'd0, 5'b01000, 1,
         64'hFFF0000000000000, 5'b01001);
    conv("R11 sub to normal", mk(0, 15'h3C00, '1), 2'd0, 5'd0, 1, 64'h0010000000000000, 5'b00101);
  endtask

  task automatic t_flags();
    conv("R12 exact sub no trap", mk(0, 15'h3BFF, '0), 2'd0, 5'd0, 1, 64'h0004000000000000, 5'd0);
    conv("R12 exact sub uf trap", mk(0, 15'h3BFF, '0), 2'd0, 5'b00100, 1,
         64'h0004000000000000, 5'b00100);
    conv("R12 inexact sub", mk(0, 15'h3BFF, 112'h1), 2'd1, 5'd0, 1, 64'h0004000000000000, 5'b00101);
  endtask

  task automatic t_trap();
    conv("R13 nx trap", mk(0, 15'h3FFF, 112'h1), 2'd0, 5'b00001);
    conv("R13 nx unmasked", mk(0, 15'h3FFF, 112'h1), 2'd0, 5'b11110);
    conv("R13 tiny uf trap", mk(1, 15'h1234, '0), 2'd0, 5'b00100);
  endtask

  task automatic t_random();
    logic [14:0] e;
    for (int n = 0; n < 2000; n++) begin
      case ($urandom() % 8)
        0: e = 15'h7FFF;
        1: e = 15'(17407 + $urandom() % 4);
        2: e = 15'h43FE;
        3: e = 15'(15361 + $urandom() % 4);
        4: e = 15'(15308 + $urandom() % 53);
        5: e = 15'h3BCB;
        6: e = 15'($urandom());
        default: e = 15'h3C00;
      endcase
      conv("R10 random", mk(1'($urandom()), e, rfrac()), 2'($urandom()), 5'($urandom()));
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_latency();
    t_nan();
    t_inf();
    t_zero();
    t_big();
    t_tiny();
    t_normal();
    t_sub();
    t_round();
    t_carry();
    t_flags();
    t_trap();
    t_random();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule